// File: doc/BRIEF.md
# Packed Colour Lookup Table

This block holds a 256-colour lookup table for a display pipeline. Two 16-bit colour entries share each 32-bit storage word, so the table is 128 words deep. A register bus writes and reads whole words through a fixed window of byte offsets from 0x200 to 0x3FC. Words read back over the bus exactly as they were written.

A second port serves the pixel path. It takes an 8-bit colour index and returns a 24-bit colour one clock later. Each entry holds three 5-bit channels. Each channel is widened to 8 bits by appending three zero bits below it. The top bit of every entry is an intensity flag, and this block does not use it. The two ports work independently, and all contents clear to zero on reset.

Top module: `clut_palette`

## Requirements
- R1: The bus port carries byte offset bits [11:2] on `bus_addr`. An address A with 0x80 <= A <= 0xFF selects storage word A - 0x80, so byte offset 0x200 + 4n maps to word n.
- R2: A write whose address lies outside 0x80..0xFF changes no stored word.
- R3: A bus read with `bus_rd_en` high returns the full stored 32-bit word on `bus_rd_data` after the next rising clock edge. This includes bits 15 and 31. With `bus_rd_en` low, `bus_rd_data` holds its value.
- R4: Colour index i selects word i >> 1. Even indices use bits [15:0] of that word, and odd indices use bits [31:16].
- R5: Within an entry, bits [4:0] are red, bits [9:5] are green and bits [14:10] are blue. The output `pix_rgb` carries red in [23:16], green in [15:8] and blue in [7:0].
- R6: Each 5-bit channel becomes an 8-bit channel equal to the 5-bit value shifted left by 3. The three low bits of each output channel are always zero.
- R7: Bit 15 of an entry has no effect on `pix_rgb`.
- R8: `pix_rgb` reflects the index presented before the previous rising edge. If a write to the same word happens on that edge, the lookup returns the value from before the write.
- R9: Reset clears every stored word, `pix_rgb` and `bus_rd_data` to zero.
- R10: A bus read whose address lies outside 0x80..0xFF returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr_en | input | 1 | Word write strobe |
| bus_rd_en | input | 1 | Word read strobe |
| bus_addr | input | 10 | Byte offset bits [11:2] |
| bus_wr_data | input | 32 | Word to store |
| bus_rd_data | output | 32 | Registered read word |
| pix_idx | input | 8 | Colour index from the pixel path |
| pix_rgb | output | 24 | Expanded colour, one cycle after the index |

## Verification
Both read results are due one rising edge after their request. The bus word appears one edge after a cycle with `bus_rd_en` high, and the colour appears one edge after `pix_idx` is presented. A write is visible to either port only from the edge after the one that stores it. The bench model works out both expected values at each rising edge, before it applies that edge's write. It then compares them with the outputs a quarter period later, on every clock. Directed checks sample at the falling edge that follows the request edge, and this ordering is what exposes the old-value rule for a write and a lookup on the same edge.

// File: rtl/clut_pkg.sv
package clut_pkg;
   localparam int CHANNELS = 3;

   function automatic int ceil_log2(input int v);
      int r;
      r = 0;
      while ((1 << r) < v) r++;
      return r;
   endfunction
endpackage

// File: rtl/clut_word_store.sv
module clut_word_store #(
   parameter  int WORDS  = 128,
   parameter  int WORD_W = 32,
   localparam int IDX_W  = clut_pkg::ceil_log2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  a_idx,
   output logic [WORD_W-1:0] a_word,
   input  logic [IDX_W-1:0]  b_idx,
   output logic [WORD_W-1:0] b_word
);
   logic [WORDS*WORD_W-1:0] flat;

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (wr_en && (wr_idx == IDX_W'(w)))
            q <= wr_data;
      end
      assign flat[w*WORD_W +: WORD_W] = q;
   end

   assign a_word = flat[a_idx*WORD_W +: WORD_W];
   assign b_word = flat[b_idx*WORD_W +: WORD_W];
endmodule

// File: rtl/clut_bus_port.sv
module clut_bus_port #(
   parameter  int ADDR_W   = 10,
   parameter  int WORD_W   = 32,
   parameter  int WORDS    = 128,
   parameter  int WIN_BASE = 'h80,
   localparam int IDX_W    = clut_pkg::ceil_log2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   output logic              st_wr,
   output logic [IDX_W-1:0]  st_idx,
   input  logic [WORD_W-1:0] st_word,
   output logic [WORD_W-1:0] rd_data
);
   logic [ADDR_W-1:0] rel;
   logic              in_win;

   assign rel    = addr - ADDR_W'(WIN_BASE);
   assign in_win = (addr >= ADDR_W'(WIN_BASE)) && (rel < ADDR_W'(WORDS));
   assign st_idx = IDX_W'(rel);
   assign st_wr  = wr_en && in_win;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data <= '0;
      else if (rd_en)
         rd_data <= in_win ? st_word : '0;
   end
endmodule

// File: rtl/clut_pix_port.sv
module clut_pix_port #(
   parameter  int ENTRIES = 256,
   parameter  int ENT_W   = 16,
   parameter  int WORD_W  = 32,
   parameter  int CH_W    = 5,
   parameter  int OUT_W   = 8,
   localparam int EPW     = WORD_W / ENT_W,
   localparam int SEL_W   = clut_pkg::ceil_log2(EPW),
   localparam int PIX_W   = clut_pkg::ceil_log2(ENTRIES),
   localparam int IDX_W   = PIX_W - SEL_W,
   localparam int RGB_W   = clut_pkg::CHANNELS * OUT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PIX_W-1:0]  pix_idx,
   output logic [IDX_W-1:0]  word_idx,
   input  logic [WORD_W-1:0] word,
   output logic [RGB_W-1:0]  rgb
);
   logic [ENT_W-1:0] ent_d;
   logic [ENT_W-1:0] ent_q;

   assign word_idx = pix_idx[PIX_W-1:SEL_W];

   if (EPW == 1) begin : g_one
      assign ent_d = word[ENT_W-1:0];
   end else begin : g_many
      logic [SEL_W-1:0] sel;
      assign sel   = pix_idx[SEL_W-1:0];
      assign ent_d = word[sel*ENT_W +: ENT_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ent_q <= '0;
      else
         ent_q <= ent_d;
   end

   for (genvar c = 0; c < clut_pkg::CHANNELS; c++) begin : g_ch
      localparam int OPOS = (clut_pkg::CHANNELS - 1 - c) * OUT_W;
      if (OUT_W == CH_W) begin : g_same
         assign rgb[OPOS +: OUT_W] = ent_q[c*CH_W +: CH_W];
      end else begin : g_wide
         assign rgb[OPOS +: OUT_W] = {ent_q[c*CH_W +: CH_W], {(OUT_W-CH_W){1'b0}}};
      end
   end
endmodule

// File: rtl/clut_palette.sv
module clut_palette #(
   parameter  int ENTRIES  = 256,
   parameter  int ENT_W    = 16,
   parameter  int WORD_W   = 32,
   parameter  int CH_W     = 5,
   parameter  int OUT_W    = 8,
   parameter  int ADDR_W   = 10,
   parameter  int WIN_BASE = 'h80,
   localparam int WORDS    = ENTRIES * ENT_W / WORD_W,
   localparam int IDX_W    = clut_pkg::ceil_log2(WORDS),
   localparam int PIX_W    = clut_pkg::ceil_log2(ENTRIES),
   localparam int RGB_W    = clut_pkg::CHANNELS * OUT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr_en,
   input  logic              bus_rd_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WORD_W-1:0] bus_wr_data,
   output logic [WORD_W-1:0] bus_rd_data,
   input  logic [PIX_W-1:0]  pix_idx,
   output logic [RGB_W-1:0]  pix_rgb
);
   if (WORD_W % ENT_W != 0) begin : g_bad_pack
      $error("word width must hold a whole number of entries");
   end
   if (clut_pkg::CHANNELS * CH_W > ENT_W) begin : g_bad_ch
      $error("channels do not fit in an entry");
   end
   if (CH_W > OUT_W) begin : g_bad_out
      $error("output channel narrower than stored channel");
   end
   if ((1 << PIX_W) != ENTRIES) begin : g_bad_ent
      $error("entry count must be a power of two");
   end
   if (WIN_BASE + WORDS > (1 << ADDR_W)) begin : g_bad_win
      $error("window does not fit in the address range");
   end

   logic              st_wr;
   logic [IDX_W-1:0]  st_idx;
   logic [WORD_W-1:0] st_word_a;
   logic [IDX_W-1:0]  px_idx;
   logic [WORD_W-1:0] st_word_b;

   clut_word_store #(.WORDS(WORDS), .WORD_W(WORD_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (st_wr),
      .wr_idx  (st_idx),
      .wr_data (bus_wr_data),
      .a_idx   (st_idx),
      .a_word  (st_word_a),
      .b_idx   (px_idx),
      .b_word  (st_word_b)
   );

   clut_bus_port #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS),
                   .WIN_BASE(WIN_BASE)) u_bus (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_wr_en),
      .rd_en   (bus_rd_en),
      .addr    (bus_addr),
      .st_wr   (st_wr),
      .st_idx  (st_idx),
      .st_word (st_word_a),
      .rd_data (bus_rd_data)
   );

   clut_pix_port #(.ENTRIES(ENTRIES), .ENT_W(ENT_W), .WORD_W(WORD_W),
                   .CH_W(CH_W), .OUT_W(OUT_W)) u_pix (
      .clk      (clk),
      .rst_n    (rst_n),
      .pix_idx  (pix_idx),
      .word_idx (px_idx),
      .word     (st_word_b),
      .rgb      (pix_rgb)
   );
endmodule

// File: rtl/clut_chk.sv
module clut_chk #(
   parameter int ADDR_W   = 10,
   parameter int WORD_W   = 32,
   parameter int PIX_W    = 8,
   parameter int RGB_W    = 24,
   parameter int OUT_W    = 8,
   parameter int CH_W     = 5,
   parameter int WIN_BASE = 'h80,
   parameter int WORDS    = 128
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr_en,
   input logic              bus_rd_en,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [WORD_W-1:0] bus_rd_data,
   input logic [PIX_W-1:0]  pix_idx,
   input logic [RGB_W-1:0]  pix_rgb
);
   logic outside;
   assign outside = (int'(bus_addr) < WIN_BASE) || (int'(bus_addr) >= WIN_BASE + WORDS);

   a_r3_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_en |=> $stable(bus_rd_data));

   a_r10_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_en && outside) |=> (bus_rd_data == '0));

   a_r8_pix_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(bus_wr_en) && $stable(pix_idx)) |=> $stable(pix_rgb));

   if (OUT_W > CH_W) begin : g_low
      a_r6_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (pix_rgb[OUT_W-CH_W-1:0] == '0 &&
                   pix_rgb[OUT_W +: OUT_W-CH_W] == '0 &&
                   pix_rgb[2*OUT_W +: OUT_W-CH_W] == '0));
   end
endmodule

bind clut_palette clut_chk #(
   .ADDR_W(ADDR_W), .WORD_W(WORD_W), .PIX_W(PIX_W), .RGB_W(RGB_W),
   .OUT_W(OUT_W), .CH_W(CH_W), .WIN_BASE(WIN_BASE), .WORDS(WORDS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_wr_en   (bus_wr_en),
   .bus_rd_en   (bus_rd_en),
   .bus_addr    (bus_addr),
   .bus_rd_data (bus_rd_data),
   .pix_idx     (pix_idx),
   .pix_rgb     (pix_rgb)
);

// File: tb/clut_palette_bench.sv
module clut_palette_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr_en = 1'b0;
   logic        bus_rd_en = 1'b0;
   logic [9:0]  bus_addr = '0;
   logic [31:0] bus_wr_data = '0;
   logic [31:0] bus_rd_data;
   logic [7:0]  pix_idx = '0;
   logic [23:0] pix_rgb;

   int    n_chk = 0;
   int    n_bad = 0;
   bit    done = 1'b0;
   string cur_req = "R9";

   logic [31:0] mdl [128];
   logic [23:0] exp_pix = '0;
   logic [31:0] exp_rd = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   clut_palette u_clut_palette (
      .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
      .bus_addr(bus_addr), .bus_wr_data(bus_wr_data), .bus_rd_data(bus_rd_data),
      .pix_idx(pix_idx), .pix_rgb(pix_rgb)
   );

   function automatic logic [23:0] to_rgb(input logic [15:0] e);
      logic [7:0] r, g, b;
      r = {e[4:0], 3'b000};
      g = {e[9:5], 3'b000};
      b = {e[14:10], 3'b000};
      return {r, g, b};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // cycle-by-cycle reference model
   always @(posedge clk) begin
      int  widx;
      bit  inw;
      logic [31:0] w;
      if (!rst_n) begin
         foreach (mdl[k]) mdl[k] = '0;
         exp_pix = '0;
         exp_rd  = '0;
      end else begin
         inw  = (bus_addr >= 10'h80) && (bus_addr <= 10'hFF);
         widx = int'(bus_addr) - 'h80;
         if (bus_rd_en) exp_rd = inw ? mdl[widx] : '0;
         w = mdl[pix_idx >> 1];
         exp_pix = to_rgb(pix_idx[0] ? w[31:16] : w[15:0]);
         if (bus_wr_en && inw) mdl[widx] = bus_wr_data;
      end
      #(CLK_PERIOD/4);
      if (!done) begin
         chk({cur_req, " pix"}, {8'h0, pix_rgb}, {8'h0, exp_pix});
         chk({cur_req, " bus"}, bus_rd_data, exp_rd);
      end
   end

   task automatic wr(input logic [9:0] a, input logic [31:0] d);
      bus_wr_en = 1'b1; bus_addr = a; bus_wr_data = d;
      @(negedge clk);
      bus_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [9:0] a, input string req, input logic [31:0] exp);
      bus_rd_en = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd_en = 1'b0;
      chk(req, bus_rd_data, exp);
   endtask

   task automatic look(input logic [7:0] i, input string req, input logic [23:0] exp);
      pix_idx = i;
      @(negedge clk);
      chk(req, {8'h0, pix_rgb}, {8'h0, exp});
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R9 reset rd", bus_rd_data, 32'h0);
      chk("R9 reset pix", {8'h0, pix_rgb}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int k = 0; k < 128; k += 37) rd(10'(10'h80 + k), "R9 word clear", 32'h0);
      look(8'd255, "R9 entry clear", 24'h0);

      cur_req = "R1";
      wr(10'h85, 32'hA5A5_F00F);
      rd(10'h85, "R1 R3 raw readback", 32'hA5A5_F00F);
      wr(10'hFF, 32'h8000_8001);
      rd(10'hFF, "R1 R3 last word", 32'h8000_8001);
      bus_addr = 10'h40;
      @(negedge clk);
      chk("R3 hold without rd_en", bus_rd_data, 32'h8000_8001);

      cur_req = "R4";
      wr(10'h8A, 32'h7C00_001F);
      look(8'd20, "R4 R5 even=low red", 24'hF80000);
      look(8'd21, "R4 R5 odd=high blue", 24'h0000F8);
      wr(10'h8B, 32'h0421_03E0);
      look(8'd22, "R5 green", 24'h00F800);
      look(8'd23, "R6 shift ones", 24'h080808);

      cur_req = "R7";
      wr(10'h8C, 32'h83E0_03E0);
      look(8'd25, "R7 intensity ignored", 24'h00F800);
      look(8'd24, "R7 reference", 24'h00F800);

      cur_req = "R2";
      wr(10'h05, 32'hFFFF_FFFF);
      wr(10'h105, 32'hFFFF_FFFF);
      wr(10'h3FF, 32'hFFFF_FFFF);
      rd(10'h85, "R2 outside write ignored", 32'hA5A5_F00F);
      rd(10'hFF, "R2 outside write ignored", 32'h8000_8001);

      cur_req = "R10";
      rd(10'h7F, "R10 below window", 32'h0);
      rd(10'h100, "R10 above window", 32'h0);

      cur_req = "R8";
      pix_idx = 8'd20;
      @(negedge clk);
      bus_wr_en = 1'b1; bus_addr = 10'h8A; bus_wr_data = 32'h0000_7FFF;
      @(negedge clk);
      bus_wr_en = 1'b0;
      chk("R8 same-edge old value", {8'h0, pix_rgb}, 32'h00F80000);
      @(negedge clk);
      chk("R8 new value next", {8'h0, pix_rgb}, 32'h00F8F8F8);

      cur_req = "R4 R5 R6 sweep";
      for (int c = 0; c < 3000; c++) begin
         bus_wr_en   = ($urandom % 3) == 0;
         bus_rd_en   = ($urandom % 2) == 0;
         bus_addr    = (($urandom % 5) == 0) ? 10'($urandom) : 10'(10'h80 + ($urandom % 128));
         bus_wr_data = $urandom;
         pix_idx     = 8'($urandom);
         @(negedge clk);
      end
      bus_wr_en = 1'b0; bus_rd_en = 1'b0;

      cur_req = "R9";
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      rd(10'h85, "R9 reset clears word", 32'h0);
      look(8'd21, "R9 reset clears entry", 24'h0);

      @(negedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule